// File: doc/BRIEF.md
# Dual-Source Supply Switching Controller

This block decides whether a small contactless device runs from its battery or from the energy it takes out of an applied magnetic field. Two comparator outputs describe the rectified coil level: one is high while the level is above the upper (switch-on) threshold, and the other is high while the level is above the lower (switch-off) threshold. Both are assumed to be already synchronous to `clk`. Every delay is a saturating counter that restarts as soon as its qualifying input drops. The change to field supply needs a short qualified interval. The return to battery needs a much longer one, and it also sends a reset pulse to the host.

The block also produces a filtered field-present flag, which is high while a field is present and low during a gap or when there is no field. It gives a one-cycle wake pulse when the supply moves to the field. Command bytes from the serial slave can turn automatic switching off or back on. While automatic switching is off, the block stays on battery until the next power-on reset or the next enable command.

Top module: `supply_switch_ctrl`

## Requirements
- R1: While `por_n` is low, and right after it is released, `sel_field_o`, `field_ok_o`, `wake_o` and `host_rst_o` are all 0, and automatic switching is enabled.
- R2: With automatic switching enabled, `sel_field_o` rises at the (T_ON+1)-th consecutive rising edge at which `above_on_i` is sampled high.
- R3: `wake_o` is high for exactly the one cycle in which `sel_field_o` first reads 1 after a switch to field.
- R4: While on field supply, `sel_field_o` falls at the (T_OFF+1)-th consecutive edge at which `above_off_i` is sampled low. From that same edge, `host_rst_o` is high for RST_LEN cycles.
- R5: A command byte with bits[7:6]=11, bits[2:0]=111 and bit3=0 disables automatic switching. `sel_field_o` is 0 two edges after the command edge, no host reset is produced, and the supply stays on battery while the field persists.
- R6: A command byte with bits[7:6]=11, bits[2:0]=111 and bit3=1 re-enables automatic switching. Any other byte value has no effect on the mode.
- R7: `field_ok_o` rises at the (G_RISE+1)-th consecutive edge with `above_on_i` high and falls at the (G_FALL+1)-th consecutive edge with `above_off_i` low. It does this whether automatic switching is enabled or not.
- R8: If a qualifying input drops before its delay expires, the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| above_on_i | input | 1 | Coil level is above the switch-on threshold |
| above_off_i | input | 1 | Coil level is above the switch-off threshold |
| cmd_valid_i | input | 1 | One-cycle strobe for a decoded command byte |
| cmd_byte_i | input | 8 | Command byte from the serial slave |
| sel_field_o | output | 1 | 1 selects field supply, 0 selects battery |
| field_ok_o | output | 1 | Filtered field-present flag (0 during a gap or with no field) |
| wake_o | output | 1 | One-cycle pulse on the switch to field |
| host_rst_o | output | 1 | Reset pulse to the host after the field is lost |

## Verification
The bench builds the block with T_ON=8, T_OFF=40, G_RISE=3, G_FALL=6 and RST_LEN=4. These values replace delays that would otherwise be hundreds to tens of thousands of cycles. With them, every expiry edge, restart-after-dip case and the full host reset window can be checked cycle by cycle within a short run. Because the gap delays are shorter than the switch delays, the field-present flag can be seen settling independently of the supply choice. This includes the case where automatic mode is disabled and the field comes and goes.

// File: rtl/supply_pkg.sv
package supply_pkg;
  typedef enum logic {SRC_BATT = 1'b0, SRC_FIELD = 1'b1} src_e;

  // Mode command: bits[7:6]=11 and bits[2:0]=111; bit3 picks disable(0)/enable(1)
  function automatic logic is_mode_cmd(input logic [7:0] b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction
endpackage

// File: rtl/qual_timer.sv
module qual_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic done_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!level_i)
      cnt_d = '0;
    else if (cnt_q != W'(LIMIT))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = level_i && (cnt_q == W'(LIMIT));
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import supply_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  output logic       auto_en_o
);
  logic en_q, en_d, hit;

  assign hit = cmd_valid_i && is_mode_cmd(cmd_byte_i);

  always_comb begin
    en_d = en_q;
    if (hit) en_d = cmd_byte_i[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_d;
  end

  assign auto_en_o = en_q;
endmodule

// File: rtl/supply_fsm.sv
module supply_fsm
  import supply_pkg::*;
#(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en_i,
  input  logic on_done_i,
  input  logic off_done_i,
  output logic sel_field_o,
  output logic wake_o,
  output logic host_rst_o
);
  localparam int RW = $clog2(RST_LEN + 1);

  src_e          src_q, src_d;
  logic          wake_q, wake_d;
  logic [RW-1:0] rcnt_q, rcnt_d;

  always_comb begin
    src_d  = src_q;
    wake_d = 1'b0;
    rcnt_d = (rcnt_q != '0) ? rcnt_q - 1'b1 : rcnt_q;
    unique case (src_q)
      SRC_BATT: begin
        if (auto_en_i && on_done_i) begin
          src_d  = SRC_FIELD;
          wake_d = 1'b1;
        end
      end
      SRC_FIELD: begin
        if (!auto_en_i) begin
          src_d = SRC_BATT;
        end else if (off_done_i) begin
          src_d  = SRC_BATT;
          rcnt_d = RW'(RST_LEN);
        end
      end
      default: src_d = SRC_BATT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_BATT;
      wake_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      src_q  <= src_d;
      wake_q <= wake_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign sel_field_o = (src_q == SRC_FIELD);
  assign wake_o      = wake_q;
  assign host_rst_o  = (rcnt_q != '0);

  // R2
  field_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_field_o) |-> ($past(on_done_i) && $past(auto_en_i)));
  // R3
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  // R4
  host_rst_after_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_o) |-> ($past(sel_field_o) && !sel_field_o));
  // R5
  disabled_on_batt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en_i |=> !sel_field_o);
endmodule

// File: rtl/gap_filter.sv
module gap_filter #(
  parameter int G_RISE = 5,
  parameter int G_FALL = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic above_on_i,
  input  logic above_off_i,
  output logic field_ok_o
);
  logic rise_done, fall_done, ok_q, ok_d;

  qual_timer #(.LIMIT(G_RISE)) u_rise (
    .clk(clk), .rst_n(rst_n), .level_i(above_on_i), .done_o(rise_done));
  qual_timer #(.LIMIT(G_FALL)) u_fall (
    .clk(clk), .rst_n(rst_n), .level_i(!above_off_i), .done_o(fall_done));

  always_comb begin
    ok_d = ok_q;
    if (rise_done)      ok_d = 1'b1;
    else if (fall_done) ok_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_d;
  end

  assign field_ok_o = ok_q;

  // R7
  gap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_ok_o) |-> $past(above_on_i));
  // R7
  gap_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field_ok_o) |-> !$past(above_off_i));
endmodule

// File: rtl/supply_switch_ctrl.sv
module supply_switch_ctrl #(
  parameter int T_ON    = 400,
  parameter int T_OFF   = 30000,
  parameter int G_RISE  = 5,
  parameter int G_FALL  = 30,
  parameter int RST_LEN = 16
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       above_on_i,
  input  logic       above_off_i,
  input  logic       cmd_valid_i,
  input  logic [7:0] cmd_byte_i,
  output logic       sel_field_o,
  output logic       field_ok_o,
  output logic       wake_o,
  output logic       host_rst_o
);
  logic auto_en, on_done, off_done;

  cmd_decode u_cmd (
    .clk(clk), .rst_n(por_n), .cmd_valid_i(cmd_valid_i),
    .cmd_byte_i(cmd_byte_i), .auto_en_o(auto_en));

  qual_timer #(.LIMIT(T_ON)) u_on_tmr (
    .clk(clk), .rst_n(por_n), .level_i(above_on_i), .done_o(on_done));

  qual_timer #(.LIMIT(T_OFF)) u_off_tmr (
    .clk(clk), .rst_n(por_n), .level_i(!above_off_i), .done_o(off_done));

  supply_fsm #(.RST_LEN(RST_LEN)) u_fsm (
    .clk(clk), .rst_n(por_n), .auto_en_i(auto_en), .on_done_i(on_done),
    .off_done_i(off_done), .sel_field_o(sel_field_o), .wake_o(wake_o),
    .host_rst_o(host_rst_o));

  gap_filter #(.G_RISE(G_RISE), .G_FALL(G_FALL)) u_gap (
    .clk(clk), .rst_n(por_n), .above_on_i(above_on_i),
    .above_off_i(above_off_i), .field_ok_o(field_ok_o));

  // R8
  field_entry_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sel_field_o) |-> $past(above_on_i));
endmodule

// File: tb/tb_supply_switch_ctrl.sv
module tb_supply_switch_ctrl;
  localparam int T_ON = 8, T_OFF = 40, G_RISE = 3, G_FALL = 6, RST_LEN = 4;
  localparam int S_SEL = 0, S_GAP = 1, S_WAKE = 2, S_HRST = 3;

  logic clk = 1'b0;
  logic por_n, above_on, above_off, cmd_valid;
  logic [7:0] cmd_byte;
  logic sel_field, field_ok, wake, host_rst;

  always #10 clk = ~clk;

  supply_switch_ctrl #(.T_ON(T_ON), .T_OFF(T_OFF), .G_RISE(G_RISE),
    .G_FALL(G_FALL), .RST_LEN(RST_LEN)) dut (
    .clk(clk), .por_n(por_n), .above_on_i(above_on), .above_off_i(above_off),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte), .sel_field_o(sel_field),
    .field_ok_o(field_ok), .wake_o(wake), .host_rst_o(host_rst));

  typedef struct {int due; int sig; logic val; string tag;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sig_val(int s);
    case (s)
      S_SEL:   return sel_field;
      S_GAP:   return field_ok;
      S_WAKE:  return wake;
      default: return host_rst;
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      S_SEL:   return "sel_field_o";
      S_GAP:   return "field_ok_o";
      S_WAKE:  return "wake_o";
      default: return "host_rst_o";
    endcase
  endfunction

  task automatic chk(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, nm, act, exp, cyc);
    end
  endtask

  task automatic push(int d, int s, logic v, string tag);
    exp_t e;
    e.due = cyc + d; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops due expectations and compares them
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        chk(q[i].tag, sig_name(q[i].sig), sig_val(q[i].sig), q[i].val);
        q.delete(i);
      end
    end
  end

  task automatic send_cmd(logic [7:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = 8'h00;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    por_n = 1'b0; above_on = 1'b0; above_off = 1'b0;
    cmd_valid = 1'b0; cmd_byte = 8'h00;
    wait_n(3);
    // R1: outputs held at zero in reset
    chk("R1", "sel_field_o", sel_field, 1'b0);
    chk("R1", "field_ok_o", field_ok, 1'b0);
    chk("R1", "wake_o", wake, 1'b0);
    chk("R1", "host_rst_o", host_rst, 1'b0);
    por_n = 1'b1;
    wait_n(2);
    chk("R1", "sel_field_o", sel_field, 1'b0);

    // R8, R7: field appears, dips before the switch delay, then holds
    above_on = 1'b1; above_off = 1'b1;
    push(3, S_GAP, 1'b0, "R7");
    push(4, S_GAP, 1'b1, "R7");
    push(4, S_SEL, 1'b0, "R8");
    wait_n(5);
    above_on = 1'b0;
    push(3, S_SEL, 1'b0, "R8");
    push(2, S_GAP, 1'b1, "R7");
    wait_n(1);
    above_on = 1'b1;
    // R2, R3: switch at T_ON+1 edges, wake for one cycle
    push(T_ON, S_SEL, 1'b0, "R2");
    push(T_ON + 1, S_SEL, 1'b1, "R2");
    push(T_ON, S_WAKE, 1'b0, "R3");
    push(T_ON + 1, S_WAKE, 1'b1, "R3");
    push(T_ON + 2, S_WAKE, 1'b0, "R3");
    wait_n(T_ON + 4);

    // R4: field removed, long delay back to battery with host reset
    above_on = 1'b0; above_off = 1'b0;
    push(G_FALL, S_GAP, 1'b1, "R7");
    push(G_FALL + 1, S_GAP, 1'b0, "R7");
    push(T_OFF, S_SEL, 1'b1, "R4");
    push(T_OFF, S_HRST, 1'b0, "R4");
    push(T_OFF + 1, S_SEL, 1'b0, "R4");
    push(T_OFF + 1, S_HRST, 1'b1, "R4");
    push(T_OFF + RST_LEN, S_HRST, 1'b1, "R4");
    push(T_OFF + RST_LEN + 1, S_HRST, 1'b0, "R4");
    push(T_OFF + 1, S_WAKE, 1'b0, "R3");
    wait_n(T_OFF + RST_LEN + 4);

    // R5: back on field, then disable command forces battery, no reset
    above_on = 1'b1; above_off = 1'b1;
    push(T_ON + 1, S_SEL, 1'b1, "R2");
    wait_n(T_ON + 4);
    send_cmd(8'hC7);
    push(1, S_SEL, 1'b0, "R5");
    push(2, S_HRST, 1'b0, "R5");
    push(15, S_SEL, 1'b0, "R5");
    wait_n(16);

    // R6: ignored byte keeps disabled, enable byte restores switching
    send_cmd(8'hCE);
    push(10, S_SEL, 1'b0, "R6");
    wait_n(11);
    send_cmd(8'hFF);
    push(1, S_SEL, 1'b1, "R6");
    push(1, S_WAKE, 1'b1, "R6");
    wait_n(3);
    send_cmd(8'h07);
    push(5, S_SEL, 1'b1, "R6");
    wait_n(6);

    // R7: gap flag still follows the field while disabled
    send_cmd(8'hC7);
    wait_n(2);
    above_on = 1'b0; above_off = 1'b0;
    push(G_FALL + 1, S_GAP, 1'b0, "R7");
    push(10, S_HRST, 1'b0, "R5");
    push(10, S_SEL, 1'b0, "R5");
    wait_n(12);
    above_on = 1'b1; above_off = 1'b1;
    push(G_RISE + 1, S_GAP, 1'b1, "R7");
    push(T_ON + 4, S_SEL, 1'b0, "R5");
    wait_n(T_ON + 6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule